// File: doc/BRIEF.md
# Early-Terminating Sequential Multiply-Accumulate Unit

This block multiplies two 32-bit integers by running the whole multiplicand against one 8-bit digit of the multiplier per clock. It stops as soon as the multiplier digits it has not yet used can no longer change the product, so small multipliers finish in fewer cycles. It covers four operations. Two return a product: the low word only, or the full 64 bits. Two add an addend in the same operation: a 32-bit addend into a low-word result, or a 64-bit addend into a full result.

A client presents operands, an operation code and a signedness flag, then raises `start_i` for one cycle while `busy_o` is low. `busy_o` stays high for the whole operation. `done_o` then pulses for one cycle while `result_o` shows the answer. The answer stays on `result_o` until the next operation completes. The controller is a state machine with six states:

- `ST_IDLE`: waits for a start.
- `ST_SETUP`: clears the partial sum and the digit index.
- `ST_SLICE`: adds one digit's partial product per cycle.
- `ST_FOLD`: folds the deferred carry into the high word.
- `ST_ADD_LO`: adds the low addend word.
- `ST_ADD_HI`: adds the high addend word.

Its transitions are:

- IDLE→SETUP on start.
- SETUP→SLICE always.
- SLICE→SLICE while the termination test fails.
- SLICE→IDLE for the low-word product.
- SLICE→FOLD for the full product.
- SLICE→ADD_LO for both accumulate forms.
- FOLD→IDLE.
- ADD_LO→IDLE for the 32-bit accumulate.
- ADD_LO→ADD_HI for the 64-bit accumulate.
- ADD_HI→IDLE.

Top module: `emac_unit`

## Requirements
- R1: `op_i` selects the operation. Bit 0 set means a 64-bit result, and bit 1 set means accumulate. Code 0 returns the low 32 bits of a×b. Code 1 returns the 64-bit product a×b.
- R2: When `signed_i` is 1, the 64-bit forms (codes 1 and 3) treat both operands as two's complement. When it is 0, they treat both as unsigned.
- R3: The 32-bit forms (codes 0 and 2) return the same low word for either value of `signed_i`, and drive `result_o[63:32]` to zero.
- R4: The multiplier is consumed one 8-bit digit per iteration, starting from the least significant digit, and no operation uses more than four iterations. The low-word product takes 1 + N cycles, where N is the number of iterations.
- R5: In unsigned mode (a 64-bit form with `signed_i` = 0), N is the smallest n ≥ 1 for which bits 31 down to 8n of b are all zero.
- R6: In sign-run mode (`signed_i` = 1, or any 32-bit form), N is the smallest n ≥ 1 for which bits 31 down to 8n−1 of b are either all zero or all one. In the all-one case the last digit counts as negative, so the result stays exact.
- R7: Compared with the low-word product, the 64-bit product and the 32-bit accumulate each take one more cycle, and the 64-bit accumulate takes two more. Latency is counted from the clock edge that samples `start_i` to the edge after which `done_o` is high.
- R8: Code 2 returns (a×b + acc[31:0]) mod 2^32, and code 3 returns (a×b + acc) mod 2^64.
- R9: A `start_i` raised while `busy_o` is high is ignored. The running operation's result and latency are unaffected.
- R10: `done_o` is high for exactly one cycle per operation, and `busy_o` is low in that cycle.
- R11: `result_o` changes only in the cycle where `done_o` rises. It holds its value while busy and after done.
- R12: After reset, `busy_o` and `done_o` are 0 and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts an operation when idle |
| op_i | input | 2 | Operation code (bit 0 wide, bit 1 accumulate) |
| signed_i | input | 1 | Two's complement operands for the 64-bit forms |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier, consumed a digit at a time |
| acc_i | input | 64 | Addend for the accumulate forms |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result, held until the next completion |

## Verification
For every operation, the bench computes the expected latency from the multiplier's digit pattern and the operation code: 1 + N, plus 0, 1 or 2. It counts clock edges from the edge that accepts the start. At each falling edge in between it expects `busy_o` high, `done_o` low and `result_o` unchanged. At the falling edge after edge L it expects `done_o` high and the reference value on `result_o`. One further cycle then confirms that the pulse has ended and the result is held.

// File: rtl/emac_pkg.sv
package emac_pkg;

    // op code: bit 0 = 64-bit result, bit 1 = accumulate
    typedef enum logic [1:0] {
        OP_MUL_LO   = 2'd0,
        OP_MUL_WIDE = 2'd1,
        OP_MAC_LO   = 2'd2,
        OP_MAC_WIDE = 2'd3
    } emac_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_SLICE  = 3'd2,
        ST_FOLD   = 3'd3,
        ST_ADD_LO = 3'd4,
        ST_ADD_HI = 3'd5
    } emac_state_e;

    function automatic logic op_is_wide(emac_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_mac(emac_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/emac_ctrl.sv
module emac_ctrl
    import emac_pkg::*;
#(
    parameter int NSLICE = 4,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic          signed_i,
    input  logic          stop_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          accept_o,
    output logic          clear_o,
    output logic          iter_o,
    output logic          fold_o,
    output logic          add_lo_o,
    output logic          add_hi_o,
    output logic          fin_o,
    output logic [IW-1:0] idx_o,
    output logic          sx_o,
    output logic          wide_o
);

    localparam int LAT_MAX = NSLICE + 3;
    localparam int LW      = $clog2(LAT_MAX + 1) + 1;

    emac_state_e state_q, state_d;
    emac_op_e    op_q;
    logic        sx_q;
    logic [IW-1:0] idx_q;
    logic        done_q;
    logic [LW-1:0] lat_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_SLICE;
            ST_SLICE: begin
                if (stop_i) begin
                    if (op_is_mac(op_q))       state_d = ST_ADD_LO;
                    else if (op_is_wide(op_q)) state_d = ST_FOLD;
                    else                       state_d = ST_IDLE;
                end
            end
            ST_FOLD:   state_d = ST_IDLE;
            ST_ADD_LO: state_d = op_is_wide(op_q) ? ST_ADD_HI : ST_IDLE;
            ST_ADD_HI: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign clear_o  = (state_q == ST_SETUP);
    assign iter_o   = (state_q == ST_SLICE);
    assign fold_o   = (state_q == ST_FOLD);
    assign add_lo_o = (state_q == ST_ADD_LO);
    assign add_hi_o = (state_q == ST_ADD_HI);
    assign fin_o    = (state_q != ST_IDLE) && (state_d == ST_IDLE);

    // outputs and per-operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MUL_LO;
            sx_q   <= 1'b0;
            idx_q  <= '0;
            done_q <= 1'b0;
            lat_q  <= '0;
        end else begin
            done_q <= fin_o;
            if (accept_o) begin
                op_q  <= emac_op_e'(op_i);
                sx_q  <= signed_i | ~op_i[0];
                lat_q <= LW'(1);
            end else if (state_q != ST_IDLE) begin
                lat_q <= lat_q + LW'(1);
            end
            if (clear_o)              idx_q <= '0;
            else if (iter_o && !stop_i) idx_q <= idx_q + IW'(1);
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign idx_o  = idx_q;
    assign sx_o   = sx_q;
    assign wide_o = op_is_wide(op_q);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                   // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                   // R10
    AST_LAT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lat_q <= LW'(LAT_MAX)));                   // R4

endmodule

// File: rtl/emac_slice.sv
module emac_slice #(
    parameter int WORD   = 32,
    parameter int SLICE  = 8,
    parameter int NSLICE = 4,
    parameter int IW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD-1:0]   a_i,
    input  logic [WORD-1:0]   b_i,
    input  logic [IW-1:0]     idx_i,
    input  logic              sx_i,
    output logic [2*WORD-1:0] pp_o,
    output logic              stop_o,
    output logic              neg_o
);

    localparam int PW = WORD + SLICE + 2;

    logic [SLICE-1:0]  digit [NSLICE];
    logic [NSLICE-1:0] zero_above;
    logic [NSLICE-1:0] run_one;
    logic [NSLICE-1:0] run_zero;

    // per-digit termination flags
    for (genvar k = 0; k < NSLICE; k++) begin : g_dig
        assign digit[k] = b_i[k*SLICE +: SLICE];
        if (k == NSLICE - 1) begin : g_top
            assign zero_above[k] = 1'b1;
            assign run_one[k]    = b_i[WORD-1];
            assign run_zero[k]   = ~b_i[WORD-1];
        end else begin : g_mid
            assign zero_above[k] = ~|b_i[WORD-1:(k+1)*SLICE];
            assign run_one[k]    = &b_i[WORD-1:(k+1)*SLICE-1];
            assign run_zero[k]   = ~|b_i[WORD-1:(k+1)*SLICE-1];
        end
    end

    logic [SLICE-1:0]    dsel;
    logic signed [PW-1:0] mcand_x, mplr_x, prod;
    logic [2*WORD-1:0]   prod_x;

    always_comb begin
        dsel    = digit[idx_i];
        stop_o  = sx_i ? (run_one[idx_i] | run_zero[idx_i]) : zero_above[idx_i];
        neg_o   = sx_i & run_one[idx_i];
        mcand_x = {{(SLICE+2){sx_i & a_i[WORD-1]}}, a_i};
        mplr_x  = {{(WORD+2){neg_o}}, dsel};
        prod    = mcand_x * mplr_x;
        prod_x  = {{(2*WORD-PW){prod[PW-1]}}, prod};
        pp_o    = prod_x << (int'(idx_i) * SLICE);
    end

    AST_LAST_SLICE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx_i) == NSLICE - 1) |-> stop_o);               // R4
    AST_UNSIGNED_NO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        !sx_i |-> !neg_o);                                     // R5
    AST_NEG_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o |-> dsel[SLICE-1]);                              // R6

endmodule

// File: rtl/emac_sum.sv
module emac_sum #(
    parameter int WORD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              iter_i,
    input  logic              fold_i,
    input  logic              add_lo_i,
    input  logic              add_hi_i,
    input  logic [2*WORD-1:0] pp_i,
    input  logic [2*WORD-1:0] addend_i,
    output logic [WORD-1:0]   lo_d_o,
    output logic [WORD-1:0]   hi_d_o
);

    logic [WORD-1:0] lo_q, hi_q, lo_d, hi_d, cy_x;
    logic            cy_q, cy_d;

    assign cy_x = {{(WORD-1){1'b0}}, cy_q};

    // two half-width adders with a carry deferred by one cycle
    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        cy_d = cy_q;
        if (clear_i) begin
            lo_d = '0;
            hi_d = '0;
            cy_d = 1'b0;
        end else if (iter_i) begin
            {cy_d, lo_d} = {1'b0, lo_q} + {1'b0, pp_i[WORD-1:0]};
            hi_d         = hi_q + pp_i[2*WORD-1:WORD] + cy_x;
        end else if (fold_i) begin
            hi_d = hi_q + cy_x;
            cy_d = 1'b0;
        end else if (add_lo_i) begin
            {cy_d, lo_d} = {1'b0, lo_q} + {1'b0, addend_i[WORD-1:0]};
            hi_d         = hi_q + cy_x;
        end else if (add_hi_i) begin
            hi_d = hi_q + addend_i[2*WORD-1:WORD] + cy_x;
            cy_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            cy_q <= 1'b0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            cy_q <= cy_d;
        end
    end

    assign lo_d_o = lo_d;
    assign hi_d_o = hi_d;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_i, iter_i, fold_i, add_lo_i, add_hi_i}));  // R7

endmodule

// File: rtl/emac_unit.sv
module emac_unit #(
    parameter int WORD  = 32,
    parameter int SLICE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              signed_i,
    input  logic [WORD-1:0]   a_i,
    input  logic [WORD-1:0]   b_i,
    input  logic [2*WORD-1:0] acc_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2*WORD-1:0] result_o
);

    localparam int NSLICE = WORD / SLICE;
    localparam int IW     = (NSLICE > 1) ? $clog2(NSLICE) : 1;

    logic accept, clear, iter, fold, add_lo, add_hi, fin, stop, neg, sx, wide;
    logic [IW-1:0]     idx;
    logic [WORD-1:0]   a_q, b_q, lo_d, hi_d;
    logic [2*WORD-1:0] acc_q, pp, result_q;

    emac_ctrl #(.NSLICE(NSLICE), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .signed_i(signed_i), .stop_i(stop), .busy_o(busy_o), .done_o(done_o),
        .accept_o(accept), .clear_o(clear), .iter_o(iter), .fold_o(fold),
        .add_lo_o(add_lo), .add_hi_o(add_hi), .fin_o(fin), .idx_o(idx),
        .sx_o(sx), .wide_o(wide)
    );

    emac_slice #(.WORD(WORD), .SLICE(SLICE), .NSLICE(NSLICE), .IW(IW)) u_slice (
        .clk(clk), .rst_n(rst_n), .a_i(a_q), .b_i(b_q), .idx_i(idx),
        .sx_i(sx), .pp_o(pp), .stop_o(stop), .neg_o(neg)
    );

    emac_sum #(.WORD(WORD)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .iter_i(iter),
        .fold_i(fold), .add_lo_i(add_lo), .add_hi_i(add_hi), .pp_i(pp),
        .addend_i(acc_q), .lo_d_o(lo_d), .hi_d_o(hi_d)
    );

    // operand capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            acc_q    <= '0;
            result_q <= '0;
        end else begin
            if (accept) begin
                a_q   <= a_i;
                b_q   <= b_i;
                acc_q <= acc_i;
            end
            if (fin) result_q <= wide ? {hi_d, lo_d} : {{WORD{1'b0}}, lo_d};
        end
    end

    assign result_o = result_q;

    AST_HIGH_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !wide) |-> (result_o[2*WORD-1:WORD] == '0));  // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(result_o));                             // R11

endmodule

// File: tb/tb_emac_unit.sv
module tb_emac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        signed_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [63:0] acc_i = '0;
    logic        busy_o, done_o;
    logic [63:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    emac_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .signed_i(signed_i), .a_i(a_i), .b_i(b_i), .acc_i(acc_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int ref_lat(input logic [1:0] op, input bit sg, input logic [31:0] b);
        bit sx;
        int n;
        sx = sg | ~op[0];
        n = 4;
        for (int k = 1; k <= 4; k++) begin
            logic [31:0] rest_u, rest_s, ones;
            rest_u = (k == 4) ? 32'd0 : (b >> (8*k));
            rest_s = b >> (8*k - 1);
            ones   = 32'hFFFF_FFFF >> (8*k - 1);
            if (sx ? (rest_s == 32'd0 || rest_s == ones) : (rest_u == 32'd0)) begin
                n = k;
                break;
            end
        end
        return 1 + n + ((op == 2'd3) ? 2 : (op == 2'd0) ? 0 : 1);
    endfunction

    function automatic logic [63:0] ref_res(input logic [1:0] op, input bit sg,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [63:0] acc);
        logic [63:0] pa, pb, prod;
        logic [31:0] lo;
        pa = sg ? {{32{a[31]}}, a} : {32'd0, a};
        pb = sg ? {{32{b[31]}}, b} : {32'd0, b};
        prod = pa * pb;
        lo = prod[31:0] + acc[31:0];
        case (op)
            2'd0:    return {32'd0, prod[31:0]};
            2'd1:    return prod;
            2'd2:    return {32'd0, lo};
            default: return prod + acc;
        endcase
    endfunction

    // one operation, compared against the reference on every cycle
    task automatic run_op(input logic [1:0] op, input bit sg, input logic [31:0] a,
                          input logic [31:0] b, input logic [63:0] acc, input bit poke,
                          input string req);
        int lat;
        logic [63:0] exp, prev;
        lat  = ref_lat(op, sg, b);
        exp  = ref_res(op, sg, a, b, acc);
        prev = result_o;
        op_i = op; signed_i = sg; a_i = a; b_i = b; acc_i = acc; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c <= lat; c++) begin
            if (poke && c == 1) begin
                // R9: start while busy with different operands
                start_i = 1'b1; a_i = ~a; b_i = 32'h0000_0003; op_i = 2'd0;
            end
            @(posedge clk);
            @(negedge clk);
            if (c == 2) start_i = 1'b0;
            if (c < lat) begin
                chk(busy_o == 1'b1 && done_o == 1'b0, "R7", "busy/done during operation",
                    {62'd0, busy_o, done_o}, 64'd2);
                chk(result_o == prev, "R11", "result held while busy", result_o, prev);
            end else begin
                chk(done_o == 1'b1 && busy_o == 1'b0, req, "done at expected latency",
                    {62'd0, busy_o, done_o}, 64'd1);
                chk(result_o == exp, req, "result value", result_o, exp);
            end
        end
        start_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R10", "done is a single pulse",
            {62'd0, busy_o, done_o}, 64'd0);
        chk(result_o == exp, "R11", "result held after done", result_o, exp);
    endtask

    initial begin
        logic [31:0] s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk(busy_o == 1'b0 && done_o == 1'b0, "R12", "busy/done after reset",
            {62'd0, busy_o, done_o}, 64'd0);
        chk(result_o == 64'd0, "R12", "result after reset", result_o, 64'd0);

        // R4/R5: digit counts, low-word product
        run_op(2'd0, 1'b0, 32'h1234_5678, 32'h0000_0000, 64'd0, 1'b0, "R4");
        run_op(2'd0, 1'b0, 32'h1234_5678, 32'h0000_0005, 64'd0, 1'b0, "R4");
        run_op(2'd1, 1'b0, 32'hDEAD_BEEF, 32'h0000_1234, 64'd0, 1'b0, "R5");
        run_op(2'd1, 1'b0, 32'hDEAD_BEEF, 32'h00AB_CDEF, 64'd0, 1'b0, "R5");
        run_op(2'd1, 1'b0, 32'hFFFF_FFFF, 32'h8000_0001, 64'd0, 1'b0, "R1");
        // R2/R5: unsigned all-ones multiplier needs all four digits
        run_op(2'd1, 1'b0, 32'h8765_4321, 32'hFFFF_FFFF, 64'd0, 1'b0, "R2");
        // R6: sign-run termination with negative final digit
        run_op(2'd1, 1'b1, 32'h8765_4321, 32'hFFFF_FFFF, 64'd0, 1'b0, "R6");
        run_op(2'd1, 1'b1, 32'h0000_1000, 32'hFFFF_FF80, 64'd0, 1'b0, "R6");
        run_op(2'd1, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FF7F, 64'd0, 1'b0, "R6");
        run_op(2'd1, 1'b1, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b0, "R2");
        // R3: narrow forms give the same low word for either sign flag
        run_op(2'd0, 1'b0, 32'hF000_000F, 32'hFFFF_FFFE, 64'd0, 1'b0, "R3");
        run_op(2'd0, 1'b1, 32'hF000_000F, 32'hFFFF_FFFE, 64'd0, 1'b0, "R3");
        // R7/R8: accumulate forms with carries across the word boundary
        run_op(2'd2, 1'b0, 32'hFFFF_FFFF, 32'h0000_0002, 64'hAAAA_AAAA_0000_0005, 1'b0, "R8");
        run_op(2'd3, 1'b0, 32'hFFFF_FFFF, 32'h0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R8");
        run_op(2'd3, 1'b1, 32'hFFFF_FFFE, 32'h0012_3456, 64'h0000_0001_FFFF_FFFF, 1'b0, "R7");
        run_op(2'd2, 1'b1, 32'h0000_0003, 32'h7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, "R7");
        // R9: start while busy is ignored
        run_op(2'd3, 1'b0, 32'h0101_0101, 32'h0102_0304, 64'h1111_2222_3333_4444, 1'b1, "R9");
        run_op(2'd0, 1'b1, 32'h0000_0007, 32'h0000_0009, 64'd0, 1'b1, "R9");

        // R1: mixed patterns with varying digit counts
        s = 32'h1357_9BDF;
        for (int i = 0; i < 48; i++) begin
            logic [31:0] ra, rb, mask;
            logic [63:0] racc;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            ra = s;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            mask = 32'hFFFF_FFFF >> (8 * (i % 4));
            rb = s & mask;
            if (i[2]) rb = ~rb;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            racc = {s, ra ^ rb};
            run_op(i[1:0], i[3], ra, rb, racc, 1'b0, "R1");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule